// File: doc/BRIEF.md
# Dual-Order Serial Register Port

This block is the slave end of a serial control link. Over it a microcontroller reads and writes a bank of 64 byte-wide registers that sit outside the block. A session begins when the active-low select goes low. It runs for sixteen serial clocks: a command byte that carries a direction flag and a six-bit register address, then one data byte. The block presents that traffic to the register bank as an address, a write byte, a one-cycle write strobe and a returned read byte.

A static mode input picks the bit order.
- **LSB-first:** one bidirectional pin carries data in both directions.
- **MSB-first:** data arrives on a dedicated input pin and leaves on the shared pin.

In both modes the direction flag is the first bit of the command byte, so the two modes place the address bits differently. The shared pin's driver is controlled by an enable output. That enable is high only while the data byte of a read is being shifted out.

A write is held pending when its session ends. It is handed to the register bank on the first serial clock edge seen with the select high, so the serial clock must pulse at least once after each write session.

Top module: `sreg_microport`

## Requirements
- R1: A falling edge of `csN` starts a new frame; the bit counter restarts, so a frame cut short leaves nothing behind and the next frame decodes from its own first bit.
- R2: With `lsbMode`=1 the command byte arrives as: direction (1 = read, 0 = write), then address bits 0,1,2,3,4,5, then one ignored bit.
- R3: With `lsbMode`=0 the command byte arrives as: direction (1 = read, 0 = write), then one ignored bit, then address bits 5,4,3,2,1,0.
- R4: Data bytes travel bit 0 first when `lsbMode`=1 and bit 7 first when `lsbMode`=0, in both the write and the read direction.
- R5: Input bits are taken from `ioIn` when `lsbMode`=1 and from `sdiIn` when `lsbMode`=0. The other input pin is ignored. Read data always leaves on `ioOut`.
- R6: Input bits are sampled on rising `sclk` edges. Output bits change on falling edges. The first read bit is on `ioOut` after the falling edge that follows the 8th rising edge.
- R7: `ioOutEn` is high only during the data byte of a read. It drops as soon as `csN` rises and stays low while `csN` is high. It is never set in a write frame.
- R8: A write is kept only if its frame had exactly 16 rising `sclk` edges. A frame with fewer or more edges writes nothing.
- R9: A kept write raises `regWe` for exactly one `sclk` cycle, starting at the first rising edge with `csN` high. During that cycle it presents the frame's address on `regAddr` and its data on `regWdata`. `regWe` is never raised by an edge that sees `csN` low.
- R10: While `rstN` is low, `regWe` and `ioOutEn` are low and any pending write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; also clocks the register-side outputs |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low frame select |
| lsbMode | input | 1 | 1 = LSB-first single-pin framing, 0 = MSB-first two-pin framing |
| ioIn | input | 1 | Value read back from the shared data pin |
| sdiIn | input | 1 | Dedicated serial input used in MSB-first framing |
| ioOut | output | 1 | Serial read data for the shared pin |
| ioOutEn | output | 1 | Drive enable for the shared pin |
| regAddr | output | 6 | Register address of the current or pending access |
| regWdata | output | 8 | Byte to be written |
| regWe | output | 1 | One-cycle write strobe |
| regRdata | input | 8 | Byte returned by the register bank for `regAddr` |

## Verification
Several internal faults show up at the ports within a few cycles:
- A bit counter off by one puts a whole command byte on the wrong register. On the next read, the wrong byte comes back, or the drive enable switches one edge early or late.
- A wrong bit order or wrong pin choice fails on the first write-then-read in the affected mode. Reading back a register written in the opposite mode exposes it too.
- A pending flag that survives a short, long or reset-interrupted frame produces a stray `regWe` one cycle after the select rises. A later read-back then returns a changed byte.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  // Strobes from the frame control to the datapath.
  typedef struct packed {
    logic shiftEn;   // rising edge: take one input bit
    logic cmdLoad;   // rising edge: this bit completes the command byte
    logic dataLoad;  // rising edge: this bit completes the data byte
    logic outLoad;   // falling edge: load the read byte into the output shifter
    logic outShift;  // falling edge: advance the output shifter
  } strobes_t;

endpackage

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
  import sreg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic     sclk,
  input  logic     rstN,
  input  logic     csN,
  input  logic     cmdRead,
  output strobes_t strb,
  output logic     regWe,
  output logic     ioOutEn
);

  localparam int CMD_W   = DATA_W;
  localparam int FRAME   = CMD_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME + 2);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] CMD_DONE  = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(FRAME + 1);

  logic [CNT_W-1:0] bitCount;
  logic             pendingWr;

  // Rising edges seen in this frame; cleared while select is high.
  always_ff @(posedge sclk or posedge csN or negedge rstN) begin
    if (!rstN)                  bitCount <= '0;
    else if (csN)               bitCount <= '0;
    else if (bitCount != CNT_MAX) bitCount <= bitCount + 1'b1;
  end

  always_comb begin
    strb.shiftEn  = !csN;
    strb.cmdLoad  = !csN && (bitCount == CMD_LAST);
    strb.dataLoad = !csN && (bitCount == DATA_LAST);
    strb.outLoad  = (bitCount == CMD_DONE);
    strb.outShift = (bitCount > CMD_DONE) && (bitCount < FRAME_END);
  end

  // Pending write: armed by the 16th edge, dropped by a 17th, issued once select is high.
  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      pendingWr <= 1'b0;
      regWe     <= 1'b0;
    end else if (csN) begin
      regWe     <= pendingWr;
      pendingWr <= 1'b0;
    end else begin
      regWe <= 1'b0;
      if (bitCount == DATA_LAST)      pendingWr <= !cmdRead;
      else if (bitCount == FRAME_END) pendingWr <= 1'b0;
    end
  end

  // Output driver enable, updated on falling edges, killed at once by select.
  always_ff @(negedge sclk or posedge csN or negedge rstN) begin
    if (!rstN)    ioOutEn <= 1'b0;
    else if (csN) ioOutEn <= 1'b0;
    else          ioOutEn <= cmdRead && (bitCount >= CMD_DONE) && (bitCount < FRAME_END);
  end

  AST_CNT_RANGE: assert property (@(posedge sclk) disable iff (!rstN)
    bitCount <= CNT_MAX);  // R1
  AST_OE_CS_HIGH: assert property (@(posedge sclk) disable iff (!rstN)
    csN |-> !ioOutEn);  // R7
  AST_OE_DATA_PHASE: assert property (@(posedge sclk) disable iff (!rstN)
    (bitCount < CMD_DONE) |-> !ioOutEn);  // R7
  AST_PEND_FROM_FRAME: assert property (@(posedge sclk) disable iff (!rstN)
    $rose(pendingWr) |-> !$past(csN));  // R8
  AST_WE_ONE_CYCLE: assert property (@(posedge sclk) disable iff (!rstN)
    regWe |=> !regWe);  // R9
  AST_WE_AFTER_CS: assert property (@(posedge sclk) disable iff (!rstN)
    $rose(regWe) |-> $past(csN));  // R9

endmodule

// File: rtl/sreg_datapath.sv
module sreg_datapath
  import sreg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - 2
) (
  input  logic              sclk,
  input  logic              rstN,
  input  logic              lsbMode,
  input  logic              ioIn,
  input  logic              sdiIn,
  input  strobes_t          strb,
  output logic              cmdRead,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata,
  output logic              ioOut
);

  localparam int CMD_W = ADDR_W + 2;

  logic              bitIn;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] byteNext;
  logic [CMD_W-1:0]  cmdNext;
  logic [ADDR_W-1:0] addrLsb;
  logic [DATA_W-1:0] byteRev;
  logic [DATA_W-1:0] rdRev;
  logic [DATA_W-1:0] outReg;

  assign bitIn    = lsbMode ? ioIn : sdiIn;
  assign byteNext = {shiftReg[DATA_W-2:0], bitIn};
  assign cmdNext  = byteNext[CMD_W-1:0];

  // Bit-order fixups: LSB-first address follows the flag, MSB-first address ends the byte.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_addrRev
    assign addrLsb[i] = cmdNext[CMD_W-2-i];
  end
  for (genvar i = 0; i < DATA_W; i++) begin : g_byteRev
    assign byteRev[i] = byteNext[DATA_W-1-i];
    assign rdRev[i]   = regRdata[DATA_W-1-i];
  end

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      cmdRead  <= 1'b0;
      regAddr  <= '0;
      regWdata <= '0;
    end else begin
      if (strb.shiftEn) shiftReg <= byteNext;
      if (strb.cmdLoad) begin
        cmdRead <= cmdNext[CMD_W-1];
        regAddr <= lsbMode ? addrLsb : cmdNext[ADDR_W-1:0];
      end
      if (strb.dataLoad) regWdata <= lsbMode ? byteRev : byteNext;
    end
  end

  // Output shifter: its top bit is always the bit on the wire.
  always_ff @(negedge sclk or negedge rstN) begin
    if (!rstN)              outReg <= '0;
    else if (strb.outLoad)  outReg <= lsbMode ? rdRev : regRdata;
    else if (strb.outShift) outReg <= {outReg[DATA_W-2:0], 1'b0};
  end

  assign ioOut = outReg[DATA_W-1];

  AST_ADDR_HOLD: assert property (@(posedge sclk) disable iff (!rstN)
    !$past(strb.cmdLoad) |-> $stable(regAddr));  // R2
  AST_WDATA_HOLD: assert property (@(posedge sclk) disable iff (!rstN)
    !$past(strb.dataLoad) |-> $stable(regWdata));  // R4

endmodule

// File: rtl/sreg_microport.sv
module sreg_microport
  import sreg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - 2
) (
  input  logic              sclk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              lsbMode,
  input  logic              ioIn,
  input  logic              sdiIn,
  output logic              ioOut,
  output logic              ioOutEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  input  logic [DATA_W-1:0] regRdata
);

  strobes_t strb;
  logic     cmdRead;

  sreg_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .sclk    (sclk),
    .rstN    (rstN),
    .csN     (csN),
    .cmdRead (cmdRead),
    .strb    (strb),
    .regWe   (regWe),
    .ioOutEn (ioOutEn)
  );

  sreg_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .sclk     (sclk),
    .rstN     (rstN),
    .lsbMode  (lsbMode),
    .ioIn     (ioIn),
    .sdiIn    (sdiIn),
    .strb     (strb),
    .cmdRead  (cmdRead),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .ioOut    (ioOut)
  );

  AST_RESET_QUIET: assert property (@(posedge sclk)
    !rstN |-> (!regWe && !ioOutEn));  // R10

endmodule

// File: tb/sreg_microport_tb.sv
`timescale 1ns/1ps
module sreg_microport_tb_top;

  logic       sclk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       lsbMode = 1'b1;
  logic       ioIn = 1'b0;
  logic       sdiIn = 1'b0;
  logic       ioOut, ioOutEn, regWe;
  logic [5:0] regAddr;
  logic [7:0] regWdata, regRdata;

  always #2.5 sclk = ~sclk;

  sreg_microport dut_i (
    .sclk(sclk), .rstN(rstN), .csN(csN), .lsbMode(lsbMode),
    .ioIn(ioIn), .sdiIn(sdiIn), .ioOut(ioOut), .ioOutEn(ioOutEn),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRdata(regRdata)
  );

  // Register bank model outside the block, plus the bench's expected copy.
  logic [7:0] bank [64];
  logic [7:0] expBank [64];
  initial for (int i = 0; i < 64; i++) begin
    bank[i]    = 8'(i * 3) ^ 8'h5A;
    expBank[i] = 8'(i * 3) ^ 8'h5A;
  end
  always @(posedge sclk) if (regWe) bank[regAddr] <= regWdata;
  assign regRdata = bank[regAddr];

  int checks = 0;
  int errors = 0;
  logic [13:0] wrQ [$];
  logic [7:0]  rdQ [$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Write monitor: every strobe must match the oldest expected write.
  always @(posedge sclk) begin
    #1;
    if (regWe) begin
      if (wrQ.size() == 0) check(1'b0, "R8 unexpected strobe", int'(regAddr), 0);
      else begin
        logic [13:0] e;
        e = wrQ.pop_front();
        check({regAddr, regWdata} == e, "R9 write addr/data", int'({regAddr, regWdata}), int'(e));
        check(csN == 1'b1, "R9 strobe with select high", int'(csN), 1);
      end
    end
  end

  // Read monitor: collect the enabled bits, reassemble per mode, compare.
  int rdCnt = 0;
  logic [7:0] rdBits;
  always @(posedge sclk) begin
    #1;
    if (ioOutEn) begin
      rdBits[rdCnt] = ioOut;
      rdCnt++;
      if (rdCnt == 8) begin
        logic [7:0] got;
        logic [7:0] e;
        for (int k = 0; k < 8; k++) got[k] = lsbMode ? rdBits[k] : rdBits[7-k];
        rdCnt = 0;
        if (rdQ.size() == 0) check(1'b0, "R7 unexpected read output", int'(got), 0);
        else begin
          e = rdQ.pop_front();
          check(got == e, "R4 read byte", int'(got), int'(e));
        end
      end
    end else rdCnt = 0;
  end

  // One frame of nclk rising edges; optional reset pulse instead of a clean end.
  task automatic frame(input bit lsb, input bit rd, input int addr, input logic [7:0] d,
                       input int nclk, input bit xBit, input bit rstAtEnd);
    logic [15:0] bits;
    logic [5:0]  a;
    a = 6'(addr);
    bits[0] = rd;
    if (lsb) begin
      for (int k = 0; k < 6; k++) bits[1+k] = a[k];
      bits[7] = xBit;
      for (int k = 0; k < 8; k++) bits[8+k] = d[k];
    end else begin
      bits[1] = xBit;
      for (int k = 0; k < 6; k++) bits[2+k] = a[5-k];
      for (int k = 0; k < 8; k++) bits[8+k] = d[7-k];
    end
    if (nclk == 16 && rd) rdQ.push_back(expBank[a]);
    if (nclk == 16 && !rd && !rstAtEnd) begin
      wrQ.push_back({a, d});
      expBank[a] = d;
    end
    @(negedge sclk);
    lsbMode = lsb;
    for (int i = 0; i < nclk; i++) begin
      if (i > 0) @(negedge sclk);
      csN <= 1'b0;
      if (lsb) begin ioIn <= (i < 16) ? bits[i] : 1'b0; sdiIn <= (i < 16) ? ~bits[i] : 1'b1; end
      else     begin sdiIn <= (i < 16) ? bits[i] : 1'b0; ioIn <= (i < 16) ? ~bits[i] : 1'b1; end
      #1;
      if (i == 7) check(ioOutEn == 1'b0, "R7 no drive during command", int'(ioOutEn), 0);
      if (i == 8) check(ioOutEn == rd, "R6 drive from 8th falling edge", int'(ioOutEn), int'(rd));
    end
    @(negedge sclk);
    csN <= 1'b1;
    if (rstAtEnd) rstN <= 1'b0;
    #1;
    check(ioOutEn == 1'b0, "R7 release on select high", int'(ioOutEn), 0);
    @(negedge sclk);
    rstN <= 1'b1;
    repeat (2) @(negedge sclk);
    #1;
    check(ioOutEn == 1'b0, "R7 idle high impedance", int'(ioOutEn), 0);
  endtask

  initial begin
    #1000000;
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge sclk);
    #1;
    check(regWe == 1'b0 && ioOutEn == 1'b0, "R10 reset state", int'({regWe, ioOutEn}), 0);
    rstN <= 1'b1;
    repeat (2) @(negedge sclk);

    frame(1, 0, 0,  8'hA5, 16, 0, 0);   // R2 R4 R5 write LSB
    frame(1, 1, 0,  8'h00, 16, 1, 0);   // R2 read LSB
    frame(0, 0, 63, 8'h3C, 16, 1, 0);   // R3 write MSB, ignored bit set
    frame(0, 1, 63, 8'hFF, 16, 0, 0);   // R3 read MSB
    frame(1, 0, 63, 8'h81, 16, 1, 0);   // R4 write LSB
    frame(0, 1, 63, 8'h00, 16, 1, 0);   // R4 cross-mode read
    frame(0, 0, 42, 8'h0F, 16, 0, 0);   // R5 write MSB
    frame(1, 1, 42, 8'h00, 16, 0, 0);   // R5 cross-mode read
    frame(1, 0, 42, 8'hFF, 10, 0, 0);   // R8 short write dropped
    frame(0, 1, 42, 8'h00, 16, 0, 0);   // R8 value unchanged
    frame(0, 0, 21, 8'h77, 18, 0, 0);   // R8 long write dropped
    frame(1, 1, 21, 8'h00, 16, 0, 0);   // R8 value unchanged
    frame(0, 1, 42, 8'h00, 12, 0, 0);   // R1 read cut short
    frame(0, 0, 17, 8'h99, 16, 1, 0);   // R1 next frame decodes cleanly
    frame(1, 1, 17, 8'h00, 16, 0, 0);   // R1 read back
    frame(1, 0, 5,  8'hEE, 16, 0, 1);   // R10 reset drops pending write
    frame(0, 1, 5,  8'h00, 16, 0, 0);   // R10 value unchanged

    repeat (4) @(negedge sclk);
    check(wrQ.size() == 0, "R9 all writes strobed", wrQ.size(), 0);
    check(rdQ.size() == 0, "R6 all reads returned", rdQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule